// File: doc/BRIEF.md
# Two-Bank Prioritised Interrupt Register Block

This block keeps the interrupt state of a multi-function peripheral. Sixteen sources are split into an upper bank and a lower bank of eight. For each bank it holds an enable byte, a pending byte, an in-service byte and a mask byte. Alongside these sit a vector byte and two plain bytes for edge polarity and pin direction. A byte-wide register port reaches all of them. Each access on that port completes after a fixed wait.

Sources arrive as single-cycle pulses that are already edge-detected. A pulse on an enabled source sets its pending bit. The block compares the pending, mask and in-service state and raises an interrupt request. When the processor acknowledges, the winning source moves from pending to in-service, and the block hands back a vector byte. Software retires an interrupt by writing a zero to its in-service bit.

Top module: `intc_top`

## Requirements
- R1: After reset every register reads 0x00, `irq` is low and `vec_valid` is low.
- R2: A request accepted in cycle k raises `bus_done` for exactly one cycle, in cycle k+WAIT_CYCLES (default 4). A read returns the register value on `bus_rdata` in that cycle, and a write returns 0x00. The write takes effect at the end of that cycle.
- R3: Writing an enable byte stores it and ANDs the matching pending byte with the written value. Enable A is at address 0 and enable B at address 1.
- R4: Writing a pending byte ANDs it with the written value, so 1 bits keep their state and 0 bits clear. Pending A is at address 2 and pending B at address 3.
- R5: Writing an in-service byte ANDs it with the written value. In-service A is at address 4 and in-service B at address 5.
- R6: The following are plain read/write bytes: mask A (address 6), mask B (address 7), vector (8), edge polarity (9) and direction (10). Reads of addresses 11 to 15 return 0xFF.
- R7: A pulse on `src_pulse[i]` sets pending bit i only when enable bit i is 1. Source i maps to bank A bit i-8 for i >= 8 and to bank B bit i for i < 8.
- R8: `irq` is high exactly when some source is both pending and unmasked and no in-service source has equal or higher priority. Priority follows the source number, so 15 (bank A bit 7) is highest and 0 (bank B bit 0) is lowest.
- R9: When `iack` is high while `irq` is high, the highest-priority pending, unmasked source clears its pending bit and sets its in-service bit. In the next cycle `vec_valid` is high for one cycle and `vec` holds the vector byte's upper nibble above the 4-bit source number.
- R10: `irq` follows a completed write to a mask or in-service byte from the cycle after the write takes effect.
- R11: `iack` while `irq` is low changes no register and leaves `vec_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Start a register access (sampled when idle) |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_done |
| bus_done | output | 1 | Access completion pulse |
| src_pulse | input | 16 | Edge-detected source pulses |
| iack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Prioritised interrupt request |
| vec | output | 8 | Vector returned on acknowledge |
| vec_valid | output | 1 | Vector valid pulse |

## Verification
The hardest state to reach from the ports is a lower-priority source pending behind a higher-priority in-service source. Reaching it takes a chain of steps, each depending on the one before. The stimulus acknowledges a low source and then a high one, so both are in service. It then pulses another low source and confirms that `irq` stays low. Finally it retires the high in-service bit and the mask bits one at a time, showing the request return and drop as the blocking priority changes.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int BYTE_W = 8;
    localparam int SRC_W  = 2 * BYTE_W;
    localparam int IDX_W  = $clog2(SRC_W);
    localparam int SEL_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_ENA_A = 4'd0,
        SEL_ENA_B = 4'd1,
        SEL_PND_A = 4'd2,
        SEL_PND_B = 4'd3,
        SEL_INS_A = 4'd4,
        SEL_INS_B = 4'd5,
        SEL_MSK_A = 4'd6,
        SEL_MSK_B = 4'd7,
        SEL_VECT  = 4'd8,
        SEL_EDGE  = 4'd9,
        SEL_DIRN  = 4'd10
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        logic [SEL_W-1:0]  sel;
        logic [BYTE_W-1:0] data;
    } bus_acc_t;

    typedef struct packed {
        logic             any;
        logic [IDX_W-1:0] idx;
    } prio_t;

    localparam logic [BYTE_W-1:0] OPEN_BYTE = '1;

    // AND one bank (hi = upper bank) of a 16-bit source vector with a byte
    function automatic logic [SRC_W-1:0] and_bank(input logic [SRC_W-1:0] v,
                                                  input logic hi,
                                                  input logic [BYTE_W-1:0] d);
        logic [SRC_W-1:0] r;
        r = v;
        if (hi) r[SRC_W-1:BYTE_W] = v[SRC_W-1:BYTE_W] & d;
        else    r[BYTE_W-1:0]     = v[BYTE_W-1:0] & d;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] bank_of(input logic [SRC_W-1:0] v,
                                                  input logic hi);
        return hi ? v[SRC_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/intc_bus_seq.sv
module intc_bus_seq
    import intc_pkg::*;
#(
    parameter int WAIT_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic                we,
    input  logic [SEL_W-1:0]    addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic                done,
    output bus_acc_t            acc
);
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYCLES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    bus_acc_t         acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            acc_q  <= '0;
        end else if (!busy_q) begin
            if (req) begin
                busy_q    <= 1'b1;
                cnt_q     <= CNT_LOAD;
                acc_q.we  <= we;
                acc_q.sel <= addr;
                acc_q.data <= wdata;
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = busy_q && (cnt_q == '0);
    assign acc  = acc_q;

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_req_after_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && req) |=> !done);

endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int WAIT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_done,
    input  logic [15:0]       src_pulse,
    input  logic              iack,
    output logic              irq,
    output logic [7:0]        vec,
    output logic              vec_valid
);
    localparam int NIB_W = BYTE_W - IDX_W;

    bus_acc_t acc;
    logic     wr;

    logic [SRC_W-1:0]  ena_q, pnd_q, ins_q, msk_q;
    logic [BYTE_W-1:0] vect_q, edge_q, dirn_q;
    logic [BYTE_W-1:0] vout_q;
    logic              vvalid_q;

    prio_t pm, sv;
    logic  ack_take;

    intc_bus_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .req   (bus_req),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .done  (bus_done),
        .acc   (acc)
    );

    assign wr = bus_done && acc.we;

    // Priority search: pending-and-unmasked, and in-service
    intc_prio_enc #(.W(SRC_W)) u_pm_enc (
        .req (pnd_q & msk_q),
        .any (pm.any),
        .idx (pm.idx)
    );

    intc_prio_enc #(.W(SRC_W)) u_sv_enc (
        .req (ins_q),
        .any (sv.any),
        .idx (sv.idx)
    );

    assign irq      = pm.any && (!sv.any || (pm.idx > sv.idx));
    assign ack_take = iack && irq;

    // Next-state of the bit-vector registers
    logic [SRC_W-1:0] ena_n, pnd_n, ins_n, msk_n;
    logic [SRC_W-1:0] ack_bit;

    always_comb begin
        ack_bit = '0;
        if (ack_take) ack_bit[pm.idx] = 1'b1;

        ena_n = ena_q;
        pnd_n = pnd_q;
        ins_n = ins_q;
        msk_n = msk_q;

        if (wr) begin
            case (acc.sel)
                SEL_ENA_A: begin
                    ena_n[SRC_W-1:BYTE_W] = acc.data;
                    pnd_n = and_bank(pnd_q, 1'b1, acc.data);
                end
                SEL_ENA_B: begin
                    ena_n[BYTE_W-1:0] = acc.data;
                    pnd_n = and_bank(pnd_q, 1'b0, acc.data);
                end
                SEL_PND_A: pnd_n = and_bank(pnd_q, 1'b1, acc.data);
                SEL_PND_B: pnd_n = and_bank(pnd_q, 1'b0, acc.data);
                SEL_INS_A: ins_n = and_bank(ins_q, 1'b1, acc.data);
                SEL_INS_B: ins_n = and_bank(ins_q, 1'b0, acc.data);
                SEL_MSK_A: msk_n[SRC_W-1:BYTE_W] = acc.data;
                SEL_MSK_B: msk_n[BYTE_W-1:0]     = acc.data;
                default: ;
            endcase
        end

        pnd_n = (pnd_n & ~ack_bit) | (src_pulse & ena_q & ena_n);
        ins_n = ins_n | ack_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q    <= '0;
            pnd_q    <= '0;
            ins_q    <= '0;
            msk_q    <= '0;
            vect_q   <= '0;
            edge_q   <= '0;
            dirn_q   <= '0;
            vout_q   <= '0;
            vvalid_q <= 1'b0;
        end else begin
            ena_q <= ena_n;
            pnd_q <= pnd_n;
            ins_q <= ins_n;
            msk_q <= msk_n;
            if (wr && acc.sel == SEL_VECT) vect_q <= acc.data;
            if (wr && acc.sel == SEL_EDGE) edge_q <= acc.data;
            if (wr && acc.sel == SEL_DIRN) dirn_q <= acc.data;
            vvalid_q <= ack_take;
            if (ack_take) vout_q <= {vect_q[BYTE_W-1:IDX_W], pm.idx};
        end
    end

    // Read mux
    logic [BYTE_W-1:0] rd_val;

    always_comb begin
        case (acc.sel)
            SEL_ENA_A: rd_val = bank_of(ena_q, 1'b1);
            SEL_ENA_B: rd_val = bank_of(ena_q, 1'b0);
            SEL_PND_A: rd_val = bank_of(pnd_q, 1'b1);
            SEL_PND_B: rd_val = bank_of(pnd_q, 1'b0);
            SEL_INS_A: rd_val = bank_of(ins_q, 1'b1);
            SEL_INS_B: rd_val = bank_of(ins_q, 1'b0);
            SEL_MSK_A: rd_val = bank_of(msk_q, 1'b1);
            SEL_MSK_B: rd_val = bank_of(msk_q, 1'b0);
            SEL_VECT:  rd_val = vect_q;
            SEL_EDGE:  rd_val = edge_q;
            SEL_DIRN:  rd_val = dirn_q;
            default:   rd_val = OPEN_BYTE;
        endcase
    end

    assign bus_rdata = (bus_done && !acc.we) ? rd_val : '0;
    assign vec       = vout_q;
    assign vec_valid = vvalid_q;

    // Pending bits never survive outside the enabled set (R3, R7)
    assert_pend_in_enable_R7: assert property (@(posedge clk) disable iff (rst)
        (pnd_q & ~ena_q) == '0);

    assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((pnd_q & msk_q) != '0));

    assert_ack_gives_vector_R9: assert property (@(posedge clk) disable iff (rst)
        (iack && irq) |=> vec_valid);

    assert_ack_sets_service_R9: assert property (@(posedge clk) disable iff (rst)
        (iack && irq && !bus_done) |=> ($countones(ins_q) == $past($countones(ins_q)) + 1));

    assert_ack_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (iack && !irq) |=> !vec_valid);

    assert_vec_nibble_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_valid) |-> (vec[BYTE_W-1:IDX_W] == vect_q[BYTE_W-1:IDX_W]
                              || $past(bus_done)));

    initial begin
        assert_nib_width: assert (NIB_W > 0);
    end

endmodule

// File: tb/tb_intc_top.sv
module tb_intc_top;
    import intc_pkg::*;

    localparam int WAIT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_done;
    logic [15:0] src_pulse = '0;
    logic        iack = 1'b0;
    logic        irq;
    logic [7:0]  vec;
    logic        vec_valid;

    intc_top #(.WAIT_CYCLES(WAIT)) dut (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
        .src_pulse(src_pulse), .iack(iack), .irq(irq),
        .vec(vec), .vec_valid(vec_valid)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         issue;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pops expected completions and compares data and latency (R2)
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_done) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected completion", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check({it.tag, " rdata"}, bus_rdata, it.exp);
                    check("R2 latency", cyc - it.issue, WAIT);
                end
            end
            if (prev_done && bus_done) check("R2 done width", 2, 1);
            prev_done <= bus_done;
        end
    end

    // Driver
    task automatic bus_op(input logic we, input logic [3:0] a, input logic [7:0] d,
                          input logic [7:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        it.issue = cyc;
        it.exp   = we ? 8'h00 : exp;
        it.tag   = tag;
        sb.push_back(it);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        repeat (WAIT) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_op(1'b1, a, d, 8'h00, "write");
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        bus_op(1'b0, a, 8'h00, exp, tag);
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk); src_pulse = m;
        @(negedge clk); src_pulse = '0;
    endtask

    task automatic ack(input logic exp_valid, input logic [7:0] exp_vec, input string tag);
        @(negedge clk); iack = 1'b1;
        @(negedge clk); iack = 1'b0;
        check({tag, " vec_valid"}, vec_valid, exp_valid);
        if (exp_valid) check({tag, " vec"}, vec, exp_vec);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check("watchdog expired", 1, 0);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 vec_valid", vec_valid, 0);
        rd(SEL_ENA_A, 8'h00, "R1 enable A");
        rd(SEL_PND_B, 8'h00, "R1 pending B");
        rd(SEL_VECT,  8'h00, "R1 vector");
        rd(4'hF,      8'hFF, "R6 unmapped");

        wr(SEL_ENA_A, 8'hFF);
        wr(SEL_ENA_B, 8'hFE);
        wr(SEL_MSK_A, 8'hFF);
        wr(SEL_MSK_B, 8'hFF);
        wr(SEL_VECT,  8'h5A);

        // R7 disabled source does not pend
        pulse(16'h0001);
        rd(SEL_PND_B, 8'h00, "R7 disabled source");
        check("R7 irq quiet", irq, 0);
        pulse(16'h0002);
        rd(SEL_PND_B, 8'h02, "R7 enabled source");
        check("R8 irq raised", irq, 1);

        // R9 acknowledge of source 1
        ack(1'b1, 8'h51, "R9 ack src1");
        check("R9 irq after ack", irq, 0);
        rd(SEL_INS_B, 8'h02, "R9 in-service B");
        rd(SEL_PND_B, 8'h00, "R9 pending B cleared");

        // R8 higher priority preempts in-service lower
        pulse(16'h0100);
        check("R8 higher over service", irq, 1);
        ack(1'b1, 8'h58, "R9 ack src8");
        rd(SEL_INS_A, 8'h01, "R9 in-service A");
        pulse(16'h0004);
        check("R8 lower blocked", irq, 0);

        // R5 / R10 in-service write
        wr(SEL_INS_A, 8'hFE);
        check("R10 irq after service write", irq, 1);
        rd(SEL_INS_A, 8'h00, "R5 in-service A cleared");
        rd(SEL_INS_B, 8'h02, "R5 in-service B kept");

        // R10 mask write
        wr(SEL_MSK_B, 8'hFB);
        check("R10 masked", irq, 0);
        wr(SEL_MSK_B, 8'hFF);
        check("R10 unmasked", irq, 1);

        // R4 pending write AND
        wr(SEL_PND_B, 8'hFF);
        rd(SEL_PND_B, 8'h04, "R4 ones keep");
        wr(SEL_PND_B, 8'hFB);
        rd(SEL_PND_B, 8'h00, "R4 zero clears");
        check("R4 irq dropped", irq, 0);

        // R3 enable write clears disabled pending
        pulse(16'h0C00);
        rd(SEL_PND_A, 8'h0C, "R3 pending before");
        wr(SEL_ENA_A, 8'hF7);
        rd(SEL_ENA_A, 8'hF7, "R3 enable stored");
        rd(SEL_PND_A, 8'h04, "R3 pending trimmed");

        // R11 ack with no request
        wr(SEL_PND_A, 8'h00);
        wr(SEL_INS_B, 8'h00);
        check("R11 irq low", irq, 0);
        ack(1'b0, 8'h00, "R11 ignored ack");
        rd(SEL_INS_A, 8'h00, "R11 in-service A");
        rd(SEL_INS_B, 8'h00, "R11 in-service B");

        // R6 plain registers
        wr(SEL_EDGE, 8'h3C);
        rd(SEL_EDGE, 8'h3C, "R6 edge");
        wr(SEL_DIRN, 8'hA5);
        rd(SEL_DIRN, 8'hA5, "R6 direction");
        rd(SEL_MSK_A, 8'hFF, "R6 mask A");

        // R9 priority among two pending
        pulse(16'h8010);
        ack(1'b1, 8'h5F, "R9 ack src15");
        rd(SEL_INS_A, 8'h80, "R9 in-service A7");
        rd(SEL_PND_B, 8'h10, "R9 lower still pending");
        check("R8 lower behind src15", irq, 0);

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", sb.size(), 0);
        report();
    end

endmodule